// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach the management registers of external Ethernet PHYs over a two-wire MDC/MDIO link. Software sees five 32-bit registers on a simple single-cycle register bus: a mode register, an address register holding the PHY and register numbers, a 16-bit write-data register, a 16-bit read-data register and a command register. Writing the command register with its start flag launches one Clause 22 transaction. Software then polls the busy flag until it clears. For a read, it then fetches the result from the read-data register.

Each transaction is a 64-bit frame made of these fields, in order:

- an all-ones preamble;
- the start pattern;
- the opcode;
- the PHY address and the register address, both MSB first;
- a two-bit turnaround;
- sixteen data bits, MSB first.

MDC is produced by dividing the system clock and runs only while a transaction is in progress. The block drives MDIO through separate output and output-enable pins and receives it on a separate input pin. During a read it releases the line from the turnaround onward, so the PHY can answer.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads as zero, busy (command bit 16) is 0, MDC is low and MDIO output-enable is low.
- R2: Register offsets and fields:
  - Offset 0x40 keeps only bit 8, the clause selector.
  - Offset 0x44 keeps the PHY address in bits 12:8 and the register address in bits 4:0.
  - Offset 0x48 keeps bits 15:0.
  - Offset 0x4C is read-only, and software writes to it have no effect.
  - Every unused bit reads as 0.
- R3: A write to offset 0x50 with bit 8 set starts a transaction when the block is idle, and busy reads 1 from the next cycle. Bit 0 of that write selects the access: 0 is read, 1 is write. A write to 0x50 with bit 8 clear starts nothing.
- R4: While busy, MDC has a period of 2*HALF_DIV system clocks. Each bit period begins with MDC low and turns high at its midpoint. While idle, MDC is low.
- R5: The frame is sent in this order: 32 one bits, then 01, then 10 for a read or 01 for a write, then the PHY address and the register address, both MSB first. Driven values change only in the cycle where MDC falls, or when a frame starts.
- R6: A write frame drives 10 on the turnaround and then the 16 write-data bits, MSB first. Output-enable stays high for all 64 bits.
- R7: A read frame releases MDIO (output-enable low) for bit times 46 to 63. It samples MDIO in on each rising MDC of bit times 48 to 63, MSB first. Once busy clears, the 16-bit result reads at offset 0x4C.
- R8: Busy stays high for exactly 128*HALF_DIV cycles and falls in the same cycle as the final MDC fall. It leaves output-enable low and MDC low.
- R9: A start request made while busy is ignored. The PHY address, register address, write data and access code are all captured when the transaction starts. Later register writes do not alter the frame in progress.
- R10: The clause selector bit reads back as written but does not change the frame format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value sensed on the line |

## Verification
A wrong bit counter or frame-shift state shows up at mdio_out or mdio_oe within one bit period, that is 2*HALF_DIV cycles. A divider fault skews the MDC edges within half a bit period. The bench therefore compares MDC, output-enable, the driven bit and the register read-back against a behavioural model on every clock. A sampling fault is only visible through the read-data register, and only once busy clears at the end of a read frame. A start-capture fault can stay hidden until the frame reaches the affected field, so the bench disturbs the address and command registers in the middle of a frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   localparam int OFS_MODE  = 'h40;
   localparam int OFS_ADDR  = 'h44;
   localparam int OFS_WDATA = 'h48;
   localparam int OFS_RDATA = 'h4C;
   localparam int OFS_CMD   = 'h50;

   localparam int CLAUSE_BIT = 8;
   localparam int START_BIT  = 8;
   localparam int OPC_BIT    = 0;
   localparam int BUSY_BIT   = 16;
   localparam int PHY_LSB    = 8;

   localparam int PHY_W  = 5;
   localparam int REG_W  = 5;
   localparam int DATA_W = 16;

   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_ev,
   output logic fall_ev
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("HALF_DIV must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             mdc_q;
   logic             wrap;

   assign wrap    = run && (cnt_q == CNT_LAST);
   assign rise_ev = wrap && !mdc_q;
   assign fall_ev = wrap && mdc_q;
   assign mdc     = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  acc_e              start_op,
   input  logic [PHY_W-1:0]  phy_ad,
   input  logic [REG_W-1:0]  reg_ad,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rise_ev,
   input  logic              fall_ev,
   input  logic              mdio_in,
   output logic              busy,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic              rd_load,
   output logic [DATA_W-1:0] rd_value
);
   localparam int FRAME_BITS = PRE_BITS + 4 + PHY_W + REG_W + 2 + DATA_W;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + 4 + PHY_W + REG_W);
   localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_BITS + 4 + PHY_W + REG_W + 2);

   generate
      if (PRE_BITS < 1) begin : g_bad_pre
         $error("PRE_BITS must be positive");
      end
   endgenerate

   logic                  busy_q;
   logic                  oe_q;
   logic                  rd_q;
   logic [IDX_W-1:0]      idx_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic [DATA_W-1:0]     rx_q;
   logic [FRAME_BITS-1:0] frame_img;
   logic [1:0]            opc;
   logic [1:0]            ta;
   logic [IDX_W-1:0]      idx_nxt;
   logic                  accept;
   logic                  last_bit;

   assign opc       = (start_op == ACC_READ) ? 2'b10 : 2'b01;
   assign ta        = (start_op == ACC_READ) ? 2'b11 : 2'b10;
   assign frame_img = {{PRE_BITS{1'b1}}, 2'b01, opc, phy_ad, reg_ad, ta, tx_data};
   assign accept    = start_req && !busy_q;
   assign last_bit  = fall_ev && (idx_q == LAST_IDX);
   assign idx_nxt   = idx_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         oe_q   <= 1'b0;
         rd_q   <= 1'b0;
         idx_q  <= '0;
         sh_q   <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         oe_q   <= 1'b1;
         rd_q   <= (start_op == ACC_READ);
         idx_q  <= '0;
         sh_q   <= frame_img;
      end else if (busy_q && fall_ev) begin
         if (last_bit) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
         end else begin
            idx_q <= idx_nxt;
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
            oe_q  <= !(rd_q && (idx_nxt >= TA_IDX));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (busy_q && rise_ev && rd_q && (idx_q >= DATA_IDX)) begin
         rx_q <= {rx_q[DATA_W-2:0], mdio_in};
      end
   end

   assign busy     = busy_q;
   assign mdio_oe  = oe_q;
   assign mdio_out = oe_q & sh_q[FRAME_BITS-1];
   assign rd_load  = busy_q && last_bit && rd_q;
   assign rd_value = rx_q;
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              busy,
   input  logic              rd_load,
   input  logic [DATA_W-1:0] rd_value,
   output logic              start_req,
   output acc_e              start_op,
   output logic [PHY_W-1:0]  phy_ad,
   output logic [REG_W-1:0]  reg_ad,
   output logic [DATA_W-1:0] tx_data
);
   localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_ADDR  = ADDR_W'(OFS_ADDR);
   localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFS_WDATA);
   localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFS_RDATA);
   localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);

   generate
      if (ADDR_W < 7) begin : g_bad_aw
         $error("ADDR_W too narrow for the register offsets");
      end
   endgenerate

   logic              wr;
   logic              c45_q;
   logic [PHY_W-1:0]  phy_q;
   logic [REG_W-1:0]  reg_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] rd_q;
   logic              unused_wdata;

   assign wr           = bus_sel && bus_we;
   assign unused_wdata = ^bus_wdata[31:16];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c45_q <= 1'b0;
         phy_q <= '0;
         reg_q <= '0;
         wd_q  <= '0;
      end else if (wr) begin
         if (bus_addr == A_MODE)  c45_q <= bus_wdata[CLAUSE_BIT];
         if (bus_addr == A_ADDR) begin
            phy_q <= bus_wdata[PHY_LSB +: PHY_W];
            reg_q <= bus_wdata[REG_W-1:0];
         end
         if (bus_addr == A_WDATA) wd_q <= bus_wdata[DATA_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_load) rd_q <= rd_value;
   end

   assign start_req = wr && (bus_addr == A_CMD) && bus_wdata[START_BIT];
   assign start_op  = acc_e'(bus_wdata[OPC_BIT]);
   assign phy_ad    = phy_q;
   assign reg_ad    = reg_q;
   assign tx_data   = wd_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_MODE:  bus_rdata[CLAUSE_BIT] = c45_q;
         A_ADDR: begin
            bus_rdata[PHY_LSB +: PHY_W] = phy_q;
            bus_rdata[REG_W-1:0]        = reg_q;
         end
         A_WDATA: bus_rdata[DATA_W-1:0] = wd_q;
         A_RDATA: bus_rdata[DATA_W-1:0] = rd_q;
         A_CMD:   bus_rdata[BUSY_BIT]   = busy;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int HALF_DIV = 4,
   parameter int PRE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic              mdio_in
);
   logic              busy_w;
   logic              start_req;
   acc_e              start_op;
   logic [PHY_W-1:0]  phy_ad;
   logic [REG_W-1:0]  reg_ad;
   logic [DATA_W-1:0] tx_data;
   logic              rd_load;
   logic [DATA_W-1:0] rd_value;
   logic              rise_ev;
   logic              fall_ev;

   mdio_csr #(.ADDR_W(ADDR_W)) u_csr (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy_w), .rd_load(rd_load), .rd_value(rd_value),
      .start_req(start_req), .start_op(start_op),
      .phy_ad(phy_ad), .reg_ad(reg_ad), .tx_data(tx_data)
   );

   mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy_w),
      .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
   );

   mdio_frame_shift #(.PRE_BITS(PRE_BITS)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .start_req(start_req), .start_op(start_op),
      .phy_ad(phy_ad), .reg_ad(reg_ad), .tx_data(tx_data),
      .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_in(mdio_in),
      .busy(busy_w), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
      .rd_load(rd_load), .rd_value(rd_value)
   );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              busy,
   input logic              mdc,
   input logic              mdio_out,
   input logic              mdio_oe
);
   // R4
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R8
   oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   // R8
   busy_end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $fell(mdc));

   // R5
   hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));

   // R3
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CMD))
                            && bus_wdata[START_BIT]));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy_w),
   .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
   localparam int H  = 4;
   localparam int NB = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_out, mdio_oe;
   logic        mdio_in = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mdio_mgmt_master #(.ADDR_W(8), .HALF_DIV(H), .PRE_BITS(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   // behavioural model state
   bit          m_busy;
   int          t;
   bit          m_rd_op;
   logic [4:0]  f_phy, f_reg;
   logic [15:0] f_wd, f_pd;
   bit          m_c45;
   logic [4:0]  m_phy, m_reg;
   logic [15:0] m_wd, m_rd;
   logic [15:0] phy_rd_data = 16'h0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h40: return {23'h0, m_c45, 8'h0};
         8'h44: return {19'h0, m_phy, 3'h0, m_reg};
         8'h48: return {16'h0, m_wd};
         8'h4C: return {16'h0, m_rd};
         8'h50: return {15'h0, m_busy, 16'h0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic exp_bit(input int b);
      if (b < 32) return 1'b1;
      case (b - 32)
         0: return 1'b0;
         1: return 1'b1;
         2: return m_rd_op ? 1'b1 : 1'b0;
         3: return m_rd_op ? 1'b0 : 1'b1;
         14: return 1'b1;
         15: return 1'b0;
         default: ;
      endcase
      if (b - 32 < 9)  return f_phy[4 - (b - 36)];
      if (b - 32 < 14) return f_reg[4 - (b - 41)];
      return f_wd[15 - (b - 48)];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; t = 0; m_rd_op = 0;
         m_c45 = 0; m_phy = '0; m_reg = '0; m_wd = '0; m_rd = '0;
         f_phy = '0; f_reg = '0; f_wd = '0; f_pd = '0;
      end else begin
         if (m_busy) begin
            t++;
            if (t == 2 * H * NB) begin
               m_busy = 0;
               if (m_rd_op) m_rd = f_pd;
            end
         end else if (bus_sel && bus_we && bus_addr == 8'h50 && bus_wdata[8]) begin
            m_busy = 1; t = 0; m_rd_op = !bus_wdata[0];
            f_phy = m_phy; f_reg = m_reg; f_wd = m_wd; f_pd = phy_rd_data;
         end
         if (bus_sel && bus_we) begin
            case (bus_addr)
               8'h40: m_c45 = bus_wdata[8];
               8'h44: begin m_phy = bus_wdata[12:8]; m_reg = bus_wdata[4:0]; end
               8'h48: m_wd = bus_wdata[15:0];
               default: ;
            endcase
         end
      end
   end

   // PHY side: answer on read data bits, line pulled high otherwise
   always @(negedge clk) begin
      int b;
      b = t / (2 * H);
      if (m_busy && m_rd_op && b >= 48) mdio_in = f_pd[15 - (b - 48)];
      else mdio_in = 1'b1;
   end

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n && !finished) begin
         logic e_mdc, e_oe, e_out;
         int b;
         b = t / (2 * H);
         e_mdc = m_busy && (((t / H) % 2) == 1);
         e_oe  = m_busy && !(m_rd_op && b >= 46);
         e_out = e_oe ? exp_bit(b) : 1'b0;
         check("R4 mdc", {31'h0, mdc}, {31'h0, e_mdc});
         check(m_rd_op ? "R7 oe" : "R6 oe", {31'h0, mdio_oe}, {31'h0, e_oe});
         check(b < 46 ? "R5 out" : "R6 out", {31'h0, mdio_out}, {31'h0, e_out});
         check(bus_addr == 8'h50 ? "R3 R8 busy" : "R2 readback", bus_rdata, m_read(bus_addr));
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0; bus_wdata = 32'h0; bus_addr = 8'h50;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
      bus_addr = 8'h50;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (m_busy) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk("R1 mode", 8'h40, 32'h0);
      rd_chk("R1 addr", 8'h44, 32'h0);
      rd_chk("R1 wdata", 8'h48, 32'h0);
      rd_chk("R1 rdata", 8'h4C, 32'h0);
      rd_chk("R1 cmd", 8'h50, 32'h0);
      check("R1 mdc", {31'h0, mdc}, 32'h0);
      check("R1 oe", {31'h0, mdio_oe}, 32'h0);
      // R2 field masks and read-only result
      wr(8'h40, 32'hFFFF_FFFF);
      rd_chk("R2 mode mask", 8'h40, 32'h0000_0100);
      wr(8'h44, 32'hFFFF_FFFF);
      rd_chk("R2 addr mask", 8'h44, 32'h0000_1F1F);
      wr(8'h48, 32'hFFFF_FFFF);
      rd_chk("R2 wdata mask", 8'h48, 32'h0000_FFFF);
      wr(8'h4C, 32'hFFFF_FFFF);
      rd_chk("R2 rdata read-only", 8'h4C, 32'h0);
      wr(8'h40, 32'h0);
      // R3 no start without bit 8
      wr(8'h50, 32'h0000_0001);
      rd_chk("R3 no start", 8'h50, 32'h0);
      // R6 write frame
      wr(8'h44, 32'h0000_150A);
      wr(8'h48, 32'h0000_A55A);
      wr(8'h50, 32'h0000_0101);
      rd_chk("R3 busy set", 8'h50, 32'h0001_0000);
      wait_idle();
      rd_chk("R8 busy clear", 8'h50, 32'h0);
      rd_chk("R6 rdata untouched", 8'h4C, 32'h0);
      // R7 read frame
      phy_rd_data = 16'hC3E1;
      wr(8'h44, 32'h0000_031E);
      wr(8'h50, 32'h0000_0100);
      wait_idle();
      rd_chk("R7 read result", 8'h4C, 32'h0000_C3E1);
      // R9 ignored start and captured fields
      phy_rd_data = 16'h5A0F;
      wr(8'h44, 32'h0000_0102);
      wr(8'h50, 32'h0000_0100);
      repeat (100) @(negedge clk);
      wr(8'h44, 32'h0000_1F1F);
      wr(8'h48, 32'h0000_0000);
      wr(8'h50, 32'h0000_0101);
      rd_chk("R9 addr reg updated", 8'h44, 32'h0000_1F1F);
      wait_idle();
      rd_chk("R9 first read kept", 8'h4C, 32'h0000_5A0F);
      rd_chk("R9 still idle", 8'h50, 32'h0);
      // R10 clause selector stored, framing unchanged
      wr(8'h40, 32'h0000_0100);
      rd_chk("R10 mode kept", 8'h40, 32'h0000_0100);
      wr(8'h48, 32'h0000_3C96);
      wr(8'h50, 32'h0000_0101);
      wait_idle();
      // back-to-back read right after busy clears
      phy_rd_data = 16'h8001;
      wr(8'h50, 32'h0000_0100);
      wait_idle();
      rd_chk("R7 back-to-back read", 8'h4C, 32'h0000_8001);
      repeat (5) @(negedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule